// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Port

This block is the clocked control and data path for one port of a synchronous static RAM. The RAM word is 36 bits wide and is divided into four 9-bit lanes. On every rising clock edge the port samples two chip selects of opposite polarity, four active-low lane enables, a read/write strobe, an address and a write word. From these it decides whether the access is a write, a read or no operation.

A write stores only the enabled lanes into a behavioural memory array. A read returns the enabled lanes on a data output that has a separate enable bit for each lane. These enable bits stand in for tri-state drivers, and a disabled lane reads as zero. An output gate acts without the clock. When it is high, every lane enable is forced off at once. A mode pin selects when read data appears. In flow-through mode it appears in the cycle right after the sampling edge. In pipelined mode it appears one cycle later.

The port has no handshake. Every edge takes one access, and read data is presented for exactly one cycle, with no back-pressure. Address generation and arbitration between ports belong to the surrounding logic.

Top module: `sram_lane_port`

## Requirements
- R1: When `cs0_n` is high or `cs1` is low at a clock edge, that access writes no lane, and the read data it produces has every lane enable low.
- R2: Lane i occupies bits 9*i to 9*i+8 of `wdata` and `rdata`, and lane i is controlled by `lane_n[i]` and reported on `rdata_en[i]`.
- R3: A selected access with `rd_wr_n` low writes exactly the lanes whose `lane_n` bit is 0 at the sampled address. The other lanes of that word keep their stored contents.
- R4: A selected access with `rd_wr_n` high sets `rdata_en[i]` only for lanes whose `lane_n` bit is 0, and only while `out_gate_n` is low. The `rdata` bits of any lane whose enable is low are zero.
- R5: A selected access with `lane_n` equal to 4'b1111 writes nothing and drives no lane.
- R6: While `out_gate_n` is high, `rdata_en` is 0 and `rdata` is 0 in the same cycle, without waiting for a clock edge. Lowering the gate restores the clocked outputs immediately.
- R7: With `pipe_mode` low, the result of an access sampled at edge k is visible between edge k and edge k+1.
- R8: With `pipe_mode` high, the result of an access sampled at edge k is visible between edge k+1 and edge k+2.
- R9: A write access drives no lane on the output. Write data is never returned as read data.
- R10: While `rst_n` is low, and after reset until a read is sampled, `rdata_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the output stages |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| lane_n | input | 4 | Lane enables, active low, bit i for lane i |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Word address |
| wdata | input | 36 | Write word, four 9-bit lanes |
| out_gate_n | input | 1 | Unclocked output gate, active low |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined read |
| rdata | output | 36 | Read word, zero in disabled lanes |
| rdata_en | output | 4 | Per-lane output drive enable |

## Verification
Two functions can overlap in one cycle in pipelined mode. The output still shows the read sampled at the previous edge, while the current edge is writing, possibly to the same word. The random stimulus mixes reads and writes back to back on a small address range so that this happens often. Each output is then compared with a bench model that captures the read data before applying the write of the same edge.

The unclocked output gate is also lowered and raised between edges while read data is presented. The bench checks that the gate takes effect without waiting for a clock edge.

// File: rtl/lane_port_pkg.sv
package lane_port_pkg;
  localparam int unsigned PORT_LANES  = 4;
  localparam int unsigned PORT_LANE_W = 9;
  localparam int unsigned PORT_ADDR_W = 6;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lane_port_pkg::*;
#(
  parameter int unsigned LANES = PORT_LANES
) (
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic [LANES-1:0] lane_n,
  input  logic             rd_wr_n,
  output logic [LANES-1:0] wr_mask,
  output logic [LANES-1:0] rd_mask
);
  acc_kind_e        kind;
  logic             selected;
  logic [LANES-1:0] lanes_on;

  assign selected = !cs0_n && cs1;
  assign lanes_on = ~lane_n;

  always_comb begin
    if (!selected || lanes_on == '0) kind = ACC_NONE;
    else if (rd_wr_n)                kind = ACC_READ;
    else                             kind = ACC_WRITE;
  end

  always_comb begin
    wr_mask = '0;
    rd_mask = '0;
    case (kind)
      ACC_READ:  rd_mask = lanes_on;
      ACC_WRITE: wr_mask = lanes_on;
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_mem.sv
module lane_mem
  import lane_port_pkg::*;
#(
  parameter int unsigned LANES  = PORT_LANES,
  parameter int unsigned LANE_W = PORT_LANE_W,
  parameter int unsigned ADDR_W = PORT_ADDR_W
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wr_mask,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rword[g*LANE_W +: LANE_W] = bank[addr];
  end
endmodule

// File: rtl/read_stage.sv
module read_stage
  import lane_port_pkg::*;
#(
  parameter int unsigned LANES  = PORT_LANES,
  parameter int unsigned LANE_W = PORT_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        rd_mask,
  input  logic [LANES*LANE_W-1:0] rword,
  output logic [LANES-1:0]        s1_mask,
  output logic [LANES*LANE_W-1:0] s1_data,
  output logic [LANES-1:0]        s2_mask,
  output logic [LANES*LANE_W-1:0] s2_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_mask <= '0;
      s1_data <= '0;
      s2_mask <= '0;
      s2_data <= '0;
    end else begin
      s1_mask <= rd_mask;
      s1_data <= rword;
      s2_mask <= s1_mask;
      s2_data <= s1_data;
    end
  end
endmodule

// File: rtl/sram_lane_port.sv
module sram_lane_port
  import lane_port_pkg::*;
#(
  parameter int unsigned LANES  = PORT_LANES,
  parameter int unsigned LANE_W = PORT_LANE_W,
  parameter int unsigned ADDR_W = PORT_ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    rd_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_gate_n,
  input  logic                    pipe_mode,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rdata_en
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic [LANES-1:0]  wr_mask, rd_mask;
  logic [WORD_W-1:0] rword;
  logic [LANES-1:0]  s1_mask, s2_mask, sel_mask;
  logic [WORD_W-1:0] s1_data, s2_data, sel_data;

  lane_decode #(.LANES(LANES)) u_dec (
    .cs0_n   (cs0_n),
    .cs1     (cs1),
    .lane_n  (lane_n),
    .rd_wr_n (rd_wr_n),
    .wr_mask (wr_mask),
    .rd_mask (rd_mask)
  );

  lane_mem #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .addr    (addr),
    .wdata   (wdata),
    .wr_mask (wr_mask),
    .rword   (rword)
  );

  read_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_rs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_mask (rd_mask),
    .rword   (rword),
    .s1_mask (s1_mask),
    .s1_data (s1_data),
    .s2_mask (s2_mask),
    .s2_data (s2_data)
  );

  assign sel_mask = pipe_mode ? s2_mask : s1_mask;
  assign sel_data = pipe_mode ? s2_data : s1_data;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign rdata_en[g] = sel_mask[g] && !out_gate_n;
    assign rdata[g*LANE_W +: LANE_W] = rdata_en[g] ? sel_data[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/lane_port_chk.sv
module lane_port_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs0_n,
  input logic                    cs1,
  input logic [LANES-1:0]        lane_n,
  input logic                    rd_wr_n,
  input logic                    out_gate_n,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic [LANES-1:0]        rdata_en,
  input logic [LANES-1:0]        s1_mask,
  input logic [LANES-1:0]        s2_mask
);
  logic [LANES*LANE_W-1:0] en_bits;
  for (genvar g = 0; g < LANES; g++) begin : g_exp
    assign en_bits[g*LANE_W +: LANE_W] = {LANE_W{rdata_en[g]}};
  end

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs0_n || !cs1) |=> (s1_mask == '0));

  p_disabled_lane_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~en_bits) == '0));

  p_read_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs0_n && cs1 && rd_wr_n) |=> (s1_mask == ~$past(lane_n)));

  p_all_lanes_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_n == '1) |=> (s1_mask == '0));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_gate_n |-> (rdata_en == '0));

  p_pipe_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (s2_mask == $past(s1_mask)));

  p_no_write_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs0_n && cs1 && !rd_wr_n) |=> (s1_mask == '0));
endmodule

bind sram_lane_port lane_port_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs0_n      (cs0_n),
  .cs1        (cs1),
  .lane_n     (lane_n),
  .rd_wr_n    (rd_wr_n),
  .out_gate_n (out_gate_n),
  .rdata      (rdata),
  .rdata_en   (rdata_en),
  .s1_mask    (s1_mask),
  .s2_mask    (s2_mask)
);

// File: tb/sim_sram_lane_port.sv
module sim_sram_lane_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs0_n, cs1, rd_wr_n, out_gate_n, pipe_mode;
  logic [3:0]  lane_n;
  logic [5:0]  addr;
  logic [35:0] wdata;
  logic [35:0] rdata;
  logic [3:0]  rdata_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [35:0] mem_m [64];
  logic [3:0]  m1_mask = '0, m2_mask = '0;
  logic [35:0] m1_data = '0, m2_data = '0;

  always #5 clk = ~clk;

  sram_lane_port u0 (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1), .lane_n(lane_n),
    .rd_wr_n(rd_wr_n), .addr(addr), .wdata(wdata), .out_gate_n(out_gate_n),
    .pipe_mode(pipe_mode), .rdata(rdata), .rdata_en(rdata_en)
  );

  function automatic logic [3:0] exp_en(input logic gate_n, input logic pm,
                                        input logic [3:0] a, input logic [3:0] b);
    if (gate_n) return 4'b0;
    return pm ? b : a;
  endfunction

  function automatic logic [35:0] exp_data(input logic [3:0] en, input logic pm,
                                           input logic [35:0] a, input logic [35:0] b);
    logic [35:0] src = pm ? b : a;
    logic [35:0] r = '0;
    for (int i = 0; i < 4; i++) if (en[i]) r[i*9 +: 9] = src[i*9 +: 9];
    return r;
  endfunction

  task automatic check_eq(input string req, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_outputs(input string req);
    logic [3:0]  e_en = exp_en(out_gate_n, pipe_mode, m1_mask, m2_mask);
    logic [35:0] e_d  = exp_data(e_en, pipe_mode, m1_data, m2_data);
    check_eq(req, {32'b0, rdata_en}, {32'b0, e_en});
    check_eq(req, rdata, e_d);
  endtask

  // Called at a falling edge; drives an access, models the rising edge, checks at the next falling edge.
  task automatic step(input logic c0n, input logic c1, input logic [3:0] ln, input logic rw,
                      input logic [5:0] a, input logic [35:0] wd, input logic pm,
                      input logic gn, input string req);
    logic [3:0] on;
    logic sel;
    cs0_n = c0n; cs1 = c1; lane_n = ln; rd_wr_n = rw; addr = a; wdata = wd;
    pipe_mode = pm; out_gate_n = gn;
    @(posedge clk);
    sel = !c0n && c1;
    on  = ~ln;
    m2_mask = m1_mask;
    m2_data = m1_data;
    m1_mask = (sel && rw) ? on : 4'b0;
    m1_data = mem_m[a];
    if (sel && !rw)
      for (int i = 0; i < 4; i++) if (on[i]) mem_m[a][i*9 +: 9] = wd[i*9 +: 9];
    @(negedge clk);
    check_outputs(req);
  endtask

  task automatic idle(input logic pm);
    step(1'b1, 1'b0, 4'hF, 1'b1, 6'd0, 36'd0, pm, 1'b0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; lane_n = 4'hF; rd_wr_n = 1'b1;
    addr = '0; wdata = '0; out_gate_n = 1'b0; pipe_mode = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R10", {32'b0, rdata_en}, 36'd0);
    check_eq("R10", rdata, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // initialise every word with full writes
    for (int w = 0; w < 64; w++) begin
      mem_m[w] = 'x;
      step(1'b0, 1'b1, 4'b0000, 1'b0, w[5:0], {$urandom(), 4'(w)}, 1'b0, 1'b0, "R9");
    end

    // R2 lane mapping: lane 2 only, flow-through
    step(1'b0, 1'b1, 4'b0000, 1'b0, 6'd5, 36'h1_2345_6789, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b1, 4'b1011, 1'b1, 6'd5, 36'd0, 1'b0, 1'b0, "R2");
    check_eq("R2", {27'b0, rdata[26:18]}, {27'b0, 9'(36'h1_2345_6789 >> 18)});
    check_eq("R2", {32'b0, rdata_en}, 36'h4);

    // R3 partial write keeps other lanes; read back all lanes
    step(1'b0, 1'b1, 4'b0101, 1'b0, 6'd5, 36'hF_FFFF_FFFF, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, 4'b0000, 1'b1, 6'd5, 36'd0, 1'b0, 1'b0, "R3");

    // R5 all lanes off while selected: no write, no drive
    step(1'b0, 1'b1, 4'b1111, 1'b0, 6'd5, 36'd0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 4'b1111, 1'b1, 6'd5, 36'd0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 4'b0000, 1'b1, 6'd5, 36'd0, 1'b0, 1'b0, "R5");

    // R1 both deselect forms try a write, then read back
    step(1'b1, 1'b1, 4'b0000, 1'b0, 6'd7, 36'd0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, 4'b0000, 1'b0, 6'd7, 36'd0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 4'b0000, 1'b1, 6'd7, 36'd0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 4'b0000, 1'b1, 6'd7, 36'd0, 1'b0, 1'b0, "R1");

    // R7 flow-through: visible one cycle only
    step(1'b0, 1'b1, 4'b0000, 1'b1, 6'd9, 36'd0, 1'b0, 1'b0, "R7");
    idle(1'b0);

    // R8 pipelined: nothing after the edge, data one cycle later
    step(1'b0, 1'b1, 4'b0000, 1'b1, 6'd9, 36'd0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, 4'b0000, 1'b0, 6'd9, 36'h0_ABCD_1234, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, 4'b0110, 1'b1, 6'd9, 36'd0, 1'b1, 1'b0, "R8");
    idle(1'b1);

    // R6 gate acts between edges
    step(1'b0, 1'b1, 4'b0000, 1'b1, 6'd9, 36'd0, 1'b0, 1'b0, "R7");
    #1 out_gate_n = 1'b1;
    #1 check_eq("R6", {32'b0, rdata_en}, 36'd0);
    check_eq("R6", rdata, 36'd0);
    out_gate_n = 1'b0;
    #1 check_outputs("R6");
    @(negedge clk);

    // random mix on a small address window
    for (int n = 0; n < 3000; n++) begin
      logic c0n = ($urandom_range(0, 7) == 0);
      logic c1  = ($urandom_range(0, 7) != 0);
      logic rw  = $urandom_range(0, 1);
      logic [3:0] ln = 4'($urandom());
      string req;
      if (c0n || !c1)      req = "R1";
      else if (ln == 4'hF) req = "R5";
      else if (!rw)        req = "R9";
      else                 req = "R4";
      step(c0n, c1, ln, rw, 6'($urandom_range(0, 3)), {$urandom(), 4'($urandom())},
           ($urandom_range(0, 1) == 1), ($urandom_range(0, 5) == 0), req);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule